// File: doc/BRIEF.md
# Streaming 256-Point Radix-2² Delay-Feedback FFT

This block computes a 256-point discrete Fourier transform on a continuous stream of complex samples. Samples enter in natural time order, one per accepted input (a valid strobe), and the spectrum leaves in bit-reversed bin order, one value per accepted input, with a strobe and a marker on the first value of each frame. Frames may follow each other with no gap. When the input strobe is low the whole pipeline holds still.

The transform is decimation in frequency. It is built from eight radix-2 butterfly stages with feedback delay lines of 128, 64, 32, 16, 8, 4, 2 and 1 samples. Stages work in pairs. Between the two stages of a pair, some samples get a multiply by −j, which is only a swap of the real and imaginary parts and one negation. After each of the first three pairs there is one general complex multiplier. Its twiddle factors e^(−j2πe/S) come from a constant table that is built at elaboration, with 256, 64 and 16 entries for the three multipliers. A counter local to the multiplier forms the table address. Each product is rounded half-up back to the datapath width, with saturation. The datapath is the input width plus eight bits, so the butterflies never overflow.

Top module: `r22_fft`

## Requirements
- R1: While reset is asserted, and after it until the pipeline has taken 265 inputs, out_valid and out_start stay low.
- R2: The first out_valid appears in the cycle after the 266th accepted input, and out_start is high with it.
- R3: Once the pipeline is full, every accepted input gives exactly one output in the next cycle, with no gaps, across back-to-back frames.
- R4: Output number m of a frame (counting from 0) holds bin k = bit-reverse of m (8 bits) of the unscaled transform X[k] = Σ x[n]·e^(−j2πnk/256). The error in each part is at most 48 + peak/4096, where peak is the largest part magnitude of that frame's spectrum.
- R5: out_start is high on the first output of every frame, which is every 256th valid output, and on no other output.
- R6: A cycle with in_valid low accepts nothing. The next cycle has no output, and the results of the frame are unchanged.
- R7: A frame that holds the most negative input value in both parts gives exactly 256 times that value at output 0, and exactly zero at every other output, with no overflow.
- R8: The twiddle multiplier rounds half-up and saturates. A sample whose twiddle exponent is 0 leaves the multiplier unchanged one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe; low stalls the pipeline |
| in_re | input | DW | Real part of the input, two's complement |
| in_im | input | DW | Imaginary part of the input, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_start | output | 1 | High on the first output of a frame |
| out_re | output | DW+LN | Real part of the spectrum value |
| out_im | output | DW+LN | Imaginary part of the spectrum value |

## Verification
The first result is due 265 accepted inputs after the first input. The bench counts accepted inputs and requires out_valid to be low at every falling edge up to the 266th. It then requires out_valid to rise at the falling edge that follows that acceptance. From then on, each output is due exactly one cycle after its input, so at every falling edge the bench requires out_valid to equal the previous cycle's accepted strobe, including across stall cycles. Spectrum values are collected by their position in the output stream and checked later against a DFT that the bench computes, with each position mapped to its bin through an 8-bit bit reversal.

// File: rtl/r22_pkg.sv
package r22_pkg;

   localparam real PI = 3.14159265358979323846;

   // A multiplier follows every odd stage except the one in the final pair.
   function automatic bit has_mult(int s, int ln);
      return ((s % 2) == 1) && (s < ln - 1);
   endfunction

   // Number of accepted inputs between the chain input and the input of stage s.
   function automatic int stage_ofs(int s, int ln);
      int o;
      o = 0;
      for (int i = 0; i < s; i++)
         o += (1 << (ln - 1 - i)) + 1 + (has_mult(i, ln) ? 1 : 0);
      return o;
   endfunction

   function automatic int mult_ofs(int s, int ln);
      return stage_ofs(s, ln) + (1 << (ln - 1 - s)) + 1;
   endfunction

   // Twiddle part scaled by 2^(tw-2): cos for imag==0, -sin otherwise.
   function automatic int tw_val(int e, int ls, int tw, int imag);
      real ang;
      real v;
      ang = 2.0 * PI * real'(e) / real'(1 << ls);
      v = (imag != 0) ? -$sin(ang) : $cos(ang);
      v = v * real'(1 << (tw - 2));
      if (v >= 0.0) return $rtoi(v + 0.5);
      return -$rtoi(0.5 - v);
   endfunction

endpackage

// File: rtl/r22_bf_stage.sv
module r22_bf_stage #(
   parameter int W     = 24,
   parameter int D     = 128,
   parameter int START = 0,
   parameter int ROT   = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic signed [W-1:0] din_re,
   input  logic signed [W-1:0] din_im,
   output logic signed [W-1:0] dout_re,
   output logic signed [W-1:0] dout_im
);
   localparam int LD = $clog2(D);
   localparam int CW = LD + ((ROT != 0) ? 2 : 1);

   if ((1 << LD) != D) begin : g_bad_delay
      $error("r22_bf_stage: D must be a power of two");
   end

   logic [CW-1:0]       cnt;
   logic                second;
   logic signed [W-1:0] x_re, x_im;
   logic signed [W-1:0] fo_re, fo_im;
   logic signed [W-1:0] fin_re, fin_im;
   logic signed [W-1:0] nx_re, nx_im;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt <= CW'(START);
      else if (en) cnt <= cnt + 1'b1;
   end

   assign second = cnt[LD];

   // Multiply by -j in the last quarter of each span of 4*D samples.
   if (ROT != 0) begin : g_rot
      logic quad3;
      assign quad3 = cnt[LD+1] & cnt[LD];
      assign x_re  = quad3 ? din_im  : din_re;
      assign x_im  = quad3 ? -din_re : din_im;
   end else begin : g_norot
      assign x_re = din_re;
      assign x_im = din_im;
   end

   assign fin_re = second ? (fo_re - x_re) : x_re;
   assign fin_im = second ? (fo_im - x_im) : x_im;
   assign nx_re  = second ? (fo_re + x_re) : fo_re;
   assign nx_im  = second ? (fo_im + x_im) : fo_im;

   if (D == 1) begin : g_dl_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fo_re <= '0;
            fo_im <= '0;
         end else if (en) begin
            fo_re <= fin_re;
            fo_im <= fin_im;
         end
      end
   end else begin : g_dl_mem
      logic signed [W-1:0] mem_re [D];
      logic signed [W-1:0] mem_im [D];
      logic [LD-1:0]       ptr;
      assign ptr   = cnt[LD-1:0];
      assign fo_re = mem_re[ptr];
      assign fo_im = mem_im[ptr];
      always_ff @(posedge clk) begin
         if (en) begin
            mem_re[ptr] <= fin_re;
            mem_im[ptr] <= fin_im;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_re <= '0;
         dout_im <= '0;
      end else if (en) begin
         dout_re <= nx_re;
         dout_im <= nx_im;
      end
   end

endmodule

// File: rtl/r22_twiddle_mult.sv
module r22_twiddle_mult #(
   parameter int W     = 24,
   parameter int TW    = 16,
   parameter int LS    = 8,
   parameter int START = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic signed [W-1:0] din_re,
   input  logic signed [W-1:0] din_im,
   output logic signed [W-1:0] dout_re,
   output logic signed [W-1:0] dout_im
);
   localparam int NT = 1 << LS;
   localparam int PW = W + TW + 1;
   localparam logic signed [PW-1:0] HALF = PW'(1) << (TW - 3);
   localparam logic signed [PW-1:0] MAXV = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
   localparam logic signed [PW-1:0] MINV = {{(PW-W+1){1'b1}}, {(W-1){1'b0}}};

   if (LS < 4 || TW < 4) begin : g_bad_param
      $error("r22_twiddle_mult: LS and TW must be at least 4");
   end

   logic [LS-1:0]        cnt;
   logic [LS-1:0]        e;
   logic signed [TW-1:0] rom_re [NT];
   logic signed [TW-1:0] rom_im [NT];
   logic signed [TW-1:0] w_re, w_im;
   logic signed [PW-1:0] p_re, p_im;

   for (genvar i = 0; i < NT; i++) begin : g_rom
      localparam logic signed [TW-1:0] CR = TW'(r22_pkg::tw_val(i, LS, TW, 0));
      localparam logic signed [TW-1:0] CI = TW'(r22_pkg::tw_val(i, LS, TW, 1));
      assign rom_re[i] = CR;
      assign rom_im[i] = CI;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt <= LS'(START);
      else if (en) cnt <= cnt + 1'b1;
   end

   // exponent = position in sub-block times bit-reversed quarter index
   assign e = {2'b00, cnt[LS-3:0]} * {{(LS-2){1'b0}}, cnt[LS-2], cnt[LS-1]};

   assign w_re = rom_re[e];
   assign w_im = rom_im[e];

   assign p_re = PW'(din_re) * PW'(w_re) - PW'(din_im) * PW'(w_im);
   assign p_im = PW'(din_re) * PW'(w_im) + PW'(din_im) * PW'(w_re);

   function automatic logic signed [W-1:0] rnd_sat(input logic signed [PW-1:0] p);
      logic signed [PW-1:0] s;
      s = (p + HALF) >>> (TW - 2);
      if (s > MAXV) return MAXV[W-1:0];
      if (s < MINV) return MINV[W-1:0];
      return s[W-1:0];
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_re <= '0;
         dout_im <= '0;
      end else if (en) begin
         dout_re <= rnd_sat(p_re);
         dout_im <= rnd_sat(p_im);
      end
   end

   // R8: exponent 0 passes the sample through unchanged
   a_r8_unit_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (e == '0)) |=> (dout_re == $past(din_re) && dout_im == $past(din_im)));

endmodule

// File: rtl/r22_fft.sv
module r22_fft #(
   parameter int DW = 16,
   parameter int LN = 8,
   parameter int TW = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic signed [DW-1:0]    in_re,
   input  logic signed [DW-1:0]    in_im,
   output logic                    out_valid,
   output logic                    out_start,
   output logic signed [DW+LN-1:0] out_re,
   output logic signed [DW+LN-1:0] out_im
);
   localparam int OW  = DW + LN;
   localparam int N   = 1 << LN;
   localparam int LAT = r22_pkg::stage_ofs(LN - 1, LN) + 1;
   localparam int FW  = $clog2(LAT + 1);

   if ((LN % 2) != 0 || LN < 4) begin : g_bad_ln
      $error("r22_fft: LN must be even and at least 4");
   end
   if (DW < 2) begin : g_bad_dw
      $error("r22_fft: DW must be at least 2");
   end

   logic signed [OW-1:0] link_re [LN+1];
   logic signed [OW-1:0] link_im [LN+1];

   assign link_re[0] = OW'(in_re);
   assign link_im[0] = OW'(in_im);

   for (genvar s = 0; s < LN; s++) begin : g_stage
      localparam int D  = 1 << (LN - 1 - s);
      localparam int SO = r22_pkg::stage_ofs(s, LN);
      logic signed [OW-1:0] s_re, s_im;

      r22_bf_stage #(
         .W     (OW),
         .D     (D),
         .START (N - (SO % N)),
         .ROT   (s % 2)
      ) i_bf (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (in_valid),
         .din_re  (link_re[s]),
         .din_im  (link_im[s]),
         .dout_re (s_re),
         .dout_im (s_im)
      );

      if (r22_pkg::has_mult(s, LN)) begin : g_mul
         localparam int MO = r22_pkg::mult_ofs(s, LN);
         r22_twiddle_mult #(
            .W     (OW),
            .TW    (TW),
            .LS    (LN - s + 1),
            .START (N - (MO % N))
         ) i_mul (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (in_valid),
            .din_re  (s_re),
            .din_im  (s_im),
            .dout_re (link_re[s+1]),
            .dout_im (link_im[s+1])
         );
      end else begin : g_pass
         assign link_re[s+1] = s_re;
         assign link_im[s+1] = s_im;
      end
   end

   assign out_re = link_re[LN];
   assign out_im = link_im[LN];

   logic [FW-1:0] fill;
   logic          full;
   logic [LN-1:0] oidx;

   assign full = (fill == FW'(LAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill      <= '0;
         oidx      <= '0;
         out_valid <= 1'b0;
         out_start <= 1'b0;
      end else begin
         out_valid <= in_valid && full;
         out_start <= in_valid && full && (oidx == '0);
         if (in_valid && !full) fill <= fill + 1'b1;
         if (in_valid && full)  oidx <= oidx + 1'b1;
      end
   end

   // checker state: valid outputs since the last frame marker
   logic [LN:0] since_start;
   logic        started;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_start <= '0;
         started     <= 1'b0;
      end else if (out_valid) begin
         since_start <= out_start ? (LN+1)'(1) : since_start + 1'b1;
         if (out_start) started <= 1'b1;
      end
   end

   a_r6_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   a_r5_start_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_start |-> out_valid);

   a_r5_start_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && started) |-> (out_start == (since_start == (LN+1)'(N))));

endmodule

// File: tb/test_r22_fft.sv
module test_r22_fft;
   localparam int CLK_PERIOD = 10;
   localparam int DW  = 16;
   localparam int LN  = 8;
   localparam int N   = 256;
   localparam int OW  = DW + LN;
   localparam int LAT = 265;
   localparam int NF  = 8;
   localparam real PI = 3.14159265358979323846;

   typedef struct packed {
      int kind;   // 0 const, 1 tone, 2 two tones, 3 impulse, 4 ramp, 5 noise, 6 most-negative const
      int amp;
      int f1;
      int f2;
      int stall;  // every third slot idle while this frame is sent
   } vec_t;

   localparam vec_t VECS [NF] = '{
      '{6, 32768, 0,   0,   0},
      '{1, 3000,  5,   0,   0},
      '{2, 2500,  64,  200, 0},
      '{3, 8000,  17,  0,   0},
      '{4, 90,    0,   0,   1},
      '{5, 4000,  3,   0,   0},
      '{1, 6000,  131, 0,   1},
      '{0, 1000,  0,   0,   0}
   };

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  in_valid = 1'b0;
   logic signed [DW-1:0]  in_re = '0;
   logic signed [DW-1:0]  in_im = '0;
   logic                  out_valid, out_start;
   logic signed [OW-1:0]  out_re, out_im;

   r22_fft #(.DW(DW), .LN(LN), .TW(16)) i_r22_fft (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_re     (in_re),
      .in_im     (in_im),
      .out_valid (out_valid),
      .out_start (out_start),
      .out_re    (out_re),
      .out_im    (out_im)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int xin_re [NF][N];
   int xin_im [NF][N];
   int yo_re  [NF][N];
   int yo_im  [NF][N];
   real ct [N];
   real st [N];

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int rint(input real v);
      if (v >= 0.0) return $rtoi(v + 0.5);
      return -$rtoi(0.5 - v);
   endfunction

   function automatic int brev(input int m);
      int r;
      r = 0;
      for (int b = 0; b < LN; b++) if (m[b]) r |= 1 << (LN - 1 - b);
      return r;
   endfunction

   task automatic make_frame(input int f);
      vec_t v;
      v = VECS[f];
      for (int n = 0; n < N; n++) begin
         int re, im;
         case (v.kind)
            0: begin re = v.amp; im = -v.amp / 2; end
            1: begin
               re = rint(v.amp * ct[(v.f1 * n) % N]);
               im = rint(v.amp * st[(v.f1 * n) % N]);
            end
            2: begin
               re = rint(v.amp * ct[(v.f1 * n) % N]);
               im = rint(v.amp * 0.5 * st[(v.f2 * n) % N]);
            end
            3: begin re = (n == v.f1) ? v.amp : 0; im = (n == v.f1) ? -v.amp : 0; end
            4: begin re = v.amp * ((n % 64) - 32); im = v.amp * ((n / 8) - 16); end
            5: begin
               re = ((n * 97 + 31) * (n + v.f1) + 7) % (2 * v.amp + 1) - v.amp;
               im = ((n * 53 + 11) * (n + 2 * v.f1) + 3) % (2 * v.amp + 1) - v.amp;
            end
            default: begin re = -v.amp; im = -v.amp; end
         endcase
         xin_re[f][n] = re;
         xin_im[f][n] = im;
      end
   endtask

   initial begin
      int sent, ocount, cyc;
      bit prev_iv, exp_v;
      string tag;

      for (int i = 0; i < N; i++) begin
         ct[i] = $cos(2.0 * PI * i / N);
         st[i] = $sin(2.0 * PI * i / N);
      end
      for (int f = 0; f < NF; f++) make_frame(f);

      // R1: reset holds the outputs low even with inputs offered
      in_valid = 1'b1;
      in_re    = 16'sd1234;
      in_im    = -16'sd77;
      repeat (3) begin
         @(negedge clk);
         chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
         chk(out_start == 1'b0, "R1", "out_start in reset", out_start, 0);
      end
      in_valid = 1'b0;
      rst_n    = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

      sent = 0; ocount = 0; cyc = 0; prev_iv = 1'b0;
      while (ocount < NF * N && cyc < 20000) begin
         int fidx;
         bit idle;
         @(negedge clk);
         cyc++;
         // output due one cycle after the accepted input numbered sent
         exp_v = prev_iv && (sent > LAT);
         if (!prev_iv)             tag = "R6";
         else if (sent <= LAT)     tag = "R1";
         else if (sent == LAT + 1) tag = "R2";
         else                      tag = "R3";
         chk(out_valid == exp_v, tag, "out_valid timing", out_valid, exp_v);
         if (out_valid) begin
            if (ocount == 0)
               chk(sent == LAT + 1, "R2", "accepted inputs at first output", sent, LAT + 1);
            chk(out_start == ((ocount % N) == 0), "R5", "out_start", out_start,
                (ocount % N) == 0);
            if (ocount < NF * N) begin
               yo_re[ocount / N][ocount % N] = int'(out_re);
               yo_im[ocount / N][ocount % N] = int'(out_im);
            end
            ocount++;
         end
         // drive the next slot
         fidx = sent / N;
         idle = (fidx < NF) && (VECS[fidx].stall != 0) && ((cyc % 3) == 0);
         if (idle) begin
            in_valid = 1'b0;
            in_re    = 16'sd5555;   // junk that must be ignored (R6)
            in_im    = -16'sd999;
         end else begin
            in_valid = 1'b1;
            in_re    = (fidx < NF) ? DW'(xin_re[fidx][sent % N]) : '0;
            in_im    = (fidx < NF) ? DW'(xin_im[fidx][sent % N]) : '0;
            sent++;
         end
         prev_iv = in_valid;
      end
      in_valid = 1'b0;
      chk(ocount >= NF * N, "R3", "watchdog: outputs collected", ocount, NF * N);

      // spectrum comparison (R4, exact frame R7/R8)
      for (int f = 0; f < NF; f++) begin
         real xr [N];
         real xi [N];
         real peak, tol;
         peak = 0.0;
         for (int k = 0; k < N; k++) begin
            xr[k] = 0.0;
            xi[k] = 0.0;
            for (int n = 0; n < N; n++) begin
               int a;
               a = (n * k) % N;
               xr[k] += xin_re[f][n] * ct[a] + xin_im[f][n] * st[a];
               xi[k] += xin_im[f][n] * ct[a] - xin_re[f][n] * st[a];
            end
            if ((xr[k] < 0 ? -xr[k] : xr[k]) > peak) peak = (xr[k] < 0 ? -xr[k] : xr[k]);
            if ((xi[k] < 0 ? -xi[k] : xi[k]) > peak) peak = (xi[k] < 0 ? -xi[k] : xi[k]);
         end
         tol = 48.0 + peak / 4096.0;
         for (int m = 0; m < N; m++) begin
            int k, er, ei;
            k  = brev(m);
            er = rint(xr[k]);
            ei = rint(xi[k]);
            if (VECS[f].kind == 6) begin
               // R7 and R8: unity twiddles must pass full-scale values exactly
               chk(yo_re[f][m] == er && yo_im[f][m] == ei, "R7",
                   $sformatf("frame %0d pos %0d im act=%0d exp=%0d", f, m, yo_im[f][m], ei),
                   yo_re[f][m], er);
            end else begin
               real dr, di;
               dr = yo_re[f][m] - xr[k];
               di = yo_im[f][m] - xi[k];
               if (dr < 0) dr = -dr;
               if (di < 0) di = -di;
               chk(dr <= tol && di <= tol, "R4",
                   $sformatf("frame %0d pos %0d bin %0d im act=%0d exp=%0d",
                             f, m, k, yo_im[f][m], ei),
                   yo_re[f][m], er);
            end
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule